// File: doc/BRIEF.md
# Critical-Word-First Line Refill Engine

This block refills one 8-word cache line after a miss. It accepts a miss with a 32-bit-word address and the way chosen for replacement. It then asks the next-level memory for a wrapping 8-beat read burst. The burst starts at the word that missed and wraps around the line.

The first returning beat is forwarded to the requester at once. Each beat is stored in a small line buffer and written into the data RAM. A requester that keeps asking for the following words of the same line gets each one as soon as it is on the bus or already in the buffer, so it does not wait for the whole line. The tag entry is invalidated when the refill starts. It is written valid only once all eight words are in place. When caching is switched off, a request becomes a single-beat read that is returned to the requester and touches neither RAM.

Top module: `cwf_line_fill`

## Requirements
- R1: `req_ready` is high only when no transaction is open. A request is taken when `req_valid` and `req_ready` are both high at a clock edge, and `busy` is high from the next cycle on. No other request is taken until `busy` has fallen. Values on `victim_way` and `cache_en` after the accepting edge have no effect.
- R2: The cycle after a line request is taken, `mem_req` is high with `mem_burst`=1 and `mem_addr` equal to the requested word address (line base, missed word in bits [2:0]). `mem_req` and `mem_addr` hold until the edge where `mem_gnt` is high.
- R3: Beat k of the burst (k = 0..7, counted after the grant, one per `mem_rvalid`) belongs to word (missed word + k) mod 8. The cycle after each beat without error, the block presents one data-RAM write with `dram_word` = that word, `dram_set` = address bits [8:3], `dram_way` = the victim way taken at acceptance, and `dram_wdata` = the beat data.
- R4: The cycle after beat 0, `rsp_valid` is high with `rsp_word` = the missed word, `rsp_data` = the beat data and `rsp_err` = that beat's error flag.
- R5: While a line refill is open and after the missed word has been returned, a held `seq_valid` with `seq_word` w is answered the cycle after the edge where word w is either arriving on the bus or already in the buffer, with that word's data and error flag. `seq_valid` is ignored before the missed word is returned and when no refill is open.
- R6: The cycle after acceptance, one tag write with `tag_valid`=0 is presented. The cycle after the last beat, a second tag write is presented with `tag_valid`=1 if no beat failed. Both writes use the same `tag_set` and `tag_way`, and `tag_value` = address bits [29:9].
- R7: A beat with `mem_rerr` is not written to the data RAM, and any word returned from it carries `rsp_err`=1. When any beat failed, the final tag write has `tag_valid`=0 and `fill_err`=1 is shown with `fill_done`.
- R8: `fill_done` pulses in the cycle after the last beat, in which `busy` is still high. `busy` is low from the next cycle.
- R9: With `cache_en`=0 at acceptance, `mem_burst`=0 and `mem_addr` is the request address. A single beat completes the transaction and is returned on the response port with its error flag. No data-RAM or tag write occurs, and `fill_done`/`fill_err` report the end of the transaction.
- R10: During and right after reset, `busy`, `mem_req`, `rsp_valid`, `dram_we`, `tag_we` and `fill_done` are 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Caching on (1) or bypass (0), sampled at acceptance |
| req_valid | input | 1 | Miss request present |
| req_addr | input | WADDR_W | Word address of the missed access |
| victim_way | input | WAY_W | Way to refill, from the replacement generator |
| req_ready | output | 1 | Block can take a request |
| busy | output | 1 | Transaction open |
| seq_valid | input | 1 | Requester wants a following word of the line |
| seq_word | input | 3 | Index of the wanted word within the line |
| rsp_valid | output | 1 | Response word valid |
| rsp_word | output | 3 | Word index of the response |
| rsp_data | output | 32 | Response data |
| rsp_err | output | 1 | Response word came from a failed beat |
| mem_req | output | 1 | Burst request to next-level memory |
| mem_addr | output | WADDR_W | Word address of the first beat |
| mem_burst | output | 1 | 1: wrapping 8-beat burst, 0: single beat |
| mem_gnt | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |
| mem_rerr | input | 1 | Read beat error |
| dram_we | output | 1 | Data RAM write enable |
| dram_way | output | WAY_W | Data RAM way |
| dram_set | output | SET_W | Data RAM set index |
| dram_word | output | 3 | Word within the line |
| dram_wdata | output | 32 | Data RAM write data |
| tag_we | output | 1 | Tag RAM write enable |
| tag_way | output | WAY_W | Tag RAM way |
| tag_set | output | SET_W | Tag RAM set index |
| tag_value | output | WADDR_W-SET_W-3 | Tag written |
| tag_valid | output | 1 | Valid bit written with the tag |
| fill_done | output | 1 | Transaction finished (one cycle) |
| fill_err | output | 1 | Some beat of the finished transaction failed |

## Verification
The assertions assume that the memory side never raises `mem_rvalid` before it has granted a request. They also assume it returns exactly the beat count that `mem_burst` asks for, and that a requester asks only for words of the line under refill. The stimulus holds to this because the bench plays the memory itself. It grants only while `mem_req` is high, sends eight or one beats as the burst type requires, and inserts idle cycles between beats. Sequential requests come from the same bench process that observes the responses. It moves `seq_word` to the next word only after the previous one has been answered. While the block is busy, new requests are driven on purpose, to show that they wait.

// File: rtl/cwf_pkg.sv
package cwf_pkg;

    localparam int LINE_WORDS = 8;
    localparam int OFF_W      = $clog2(LINE_WORDS);
    localparam int WORD_W     = 32;

    typedef logic [OFF_W-1:0]  word_idx_t;
    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_FINISH
    } fill_state_e;

    typedef struct packed {
        word_t data;
        logic  err;
    } beat_t;

    // Word position of beat number cnt in a burst that starts at crit;
    // the index width gives the wrap around the line.
    function automatic word_idx_t wrap_idx(word_idx_t crit, word_idx_t cnt);
        return crit + cnt;
    endfunction

endpackage

// File: rtl/cwf_beat_seq.sv
module cwf_beat_seq
    import cwf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load,
    input  word_idx_t crit_in,
    input  logic      step,
    output word_idx_t idx,
    output logic      first,
    output logic      last
);

    word_idx_t crit_q;
    word_idx_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            crit_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            crit_q <= crit_in;
            cnt_q  <= '0;
        end else if (step) begin
            cnt_q  <= cnt_q + word_idx_t'(1);
        end
    end

    assign idx   = wrap_idx(crit_q, cnt_q);
    assign first = (cnt_q == '0);
    assign last  = (cnt_q == word_idx_t'(LINE_WORDS - 1));

endmodule

// File: rtl/cwf_line_buf.sv
module cwf_line_buf
    import cwf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      wr_en,
    input  word_idx_t wr_idx,
    input  beat_t     wr_beat,
    input  word_idx_t rd_idx,
    output beat_t     rd_beat,
    output logic      rd_have
);

    beat_t                 slot_q [LINE_WORDS];
    logic [LINE_WORDS-1:0] have_q;

    for (genvar g = 0; g < LINE_WORDS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == word_idx_t'(g)) begin
                slot_q[g] <= wr_beat;
            end
        end

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                have_q[g] <= 1'b0;
            end else if (wr_en && wr_idx == word_idx_t'(g)) begin
                have_q[g] <= 1'b1;
            end
        end
    end

    assign rd_beat = slot_q[rd_idx];
    assign rd_have = have_q[rd_idx];

endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill
    import cwf_pkg::*;
#(
    parameter int WADDR_W = 30,
    parameter int SET_W   = 6,
    parameter int WAY_W   = 2
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             cache_en,
    input  logic                             req_valid,
    input  logic [WADDR_W-1:0]               req_addr,
    input  logic [WAY_W-1:0]                 victim_way,
    output logic                             req_ready,
    output logic                             busy,
    input  logic                             seq_valid,
    input  logic [2:0]                       seq_word,
    output logic                             rsp_valid,
    output logic [2:0]                       rsp_word,
    output logic [31:0]                      rsp_data,
    output logic                             rsp_err,
    output logic                             mem_req,
    output logic [WADDR_W-1:0]               mem_addr,
    output logic                             mem_burst,
    input  logic                             mem_gnt,
    input  logic                             mem_rvalid,
    input  logic [31:0]                      mem_rdata,
    input  logic                             mem_rerr,
    output logic                             dram_we,
    output logic [WAY_W-1:0]                 dram_way,
    output logic [SET_W-1:0]                 dram_set,
    output logic [2:0]                       dram_word,
    output logic [31:0]                      dram_wdata,
    output logic                             tag_we,
    output logic [WAY_W-1:0]                 tag_way,
    output logic [SET_W-1:0]                 tag_set,
    output logic [WADDR_W-SET_W-3-1:0]       tag_value,
    output logic                             tag_valid,
    output logic                             fill_done,
    output logic                             fill_err
);

    localparam int TAG_W = WADDR_W - SET_W - OFF_W;

    fill_state_e state_q;
    logic [WAY_W-1:0] way_q;
    logic             crit_sent_q;
    logic             any_err_q;

    logic      accept, beat, last_beat;
    word_idx_t beat_idx;
    logic      beat_first, beat_last;
    beat_t     bus_beat, buf_beat;
    logic      buf_have;
    logic      stream_ok, from_bus, from_buf, take_bus;

    assign req_ready = (state_q == ST_IDLE);
    assign busy      = (state_q != ST_IDLE);
    assign mem_req   = (state_q == ST_ADDR);
    assign accept    = req_valid && req_ready;
    assign beat      = (state_q == ST_DATA) && mem_rvalid;
    assign last_beat = beat && (beat_last || !mem_burst);
    assign bus_beat  = '{data: mem_rdata, err: mem_rerr};

    cwf_beat_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .crit_in (req_addr[OFF_W-1:0]),
        .step    (beat),
        .idx     (beat_idx),
        .first   (beat_first),
        .last    (beat_last)
    );

    cwf_line_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .wr_en   (beat && mem_burst),
        .wr_idx  (beat_idx),
        .wr_beat (bus_beat),
        .rd_idx  (seq_word),
        .rd_beat (buf_beat),
        .rd_have (buf_have)
    );

    // Streaming of following words once the missed word has gone out.
    assign stream_ok = mem_burst && crit_sent_q && seq_valid &&
                       (state_q == ST_DATA || state_q == ST_FINISH);
    assign from_bus  = beat && stream_ok && (seq_word == beat_idx);
    assign from_buf  = stream_ok && buf_have && !from_bus;
    assign take_bus  = beat && (beat_first || from_bus);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:   if (accept)    state_q <= ST_ADDR;
                ST_ADDR:   if (mem_gnt)   state_q <= ST_DATA;
                ST_DATA:   if (last_beat) state_q <= ST_FINISH;
                ST_FINISH:                state_q <= ST_IDLE;
                default:                  state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr    <= '0;
            mem_burst   <= 1'b0;
            way_q       <= '0;
            crit_sent_q <= 1'b0;
            any_err_q   <= 1'b0;
        end else if (accept) begin
            mem_addr    <= req_addr;
            mem_burst   <= cache_en;
            way_q       <= victim_way;
            crit_sent_q <= 1'b0;
            any_err_q   <= 1'b0;
        end else if (beat) begin
            crit_sent_q <= 1'b1;
            any_err_q   <= any_err_q || mem_rerr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid  <= 1'b0;
            rsp_word   <= '0;
            rsp_data   <= '0;
            rsp_err    <= 1'b0;
            dram_we    <= 1'b0;
            dram_way   <= '0;
            dram_set   <= '0;
            dram_word  <= '0;
            dram_wdata <= '0;
            tag_we     <= 1'b0;
            tag_way    <= '0;
            tag_set    <= '0;
            tag_value  <= '0;
            tag_valid  <= 1'b0;
            fill_done  <= 1'b0;
            fill_err   <= 1'b0;
        end else begin
            rsp_valid <= (beat && beat_first) || from_bus || from_buf;
            if (take_bus) begin
                rsp_word <= beat_idx;
                rsp_data <= bus_beat.data;
                rsp_err  <= bus_beat.err;
            end else if (from_buf) begin
                rsp_word <= seq_word;
                rsp_data <= buf_beat.data;
                rsp_err  <= buf_beat.err;
            end

            dram_we    <= beat && mem_burst && !mem_rerr;
            dram_way   <= way_q;
            dram_set   <= mem_addr[OFF_W +: SET_W];
            dram_word  <= beat_idx;
            dram_wdata <= mem_rdata;

            tag_we <= (accept && cache_en) || (last_beat && mem_burst);
            if (accept) begin
                tag_way   <= victim_way;
                tag_set   <= req_addr[OFF_W +: SET_W];
                tag_value <= req_addr[WADDR_W-1 -: TAG_W];
                tag_valid <= 1'b0;
            end else begin
                tag_way   <= way_q;
                tag_set   <= mem_addr[OFF_W +: SET_W];
                tag_value <= mem_addr[WADDR_W-1 -: TAG_W];
                tag_valid <= last_beat && !(any_err_q || mem_rerr);
            end

            fill_done <= last_beat;
            fill_err  <= last_beat && (any_err_q || mem_rerr);
        end
    end

endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
    parameter int WADDR_W = 30
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               busy,
    input logic               mem_req,
    input logic               mem_gnt,
    input logic [WADDR_W-1:0] mem_addr,
    input logic               mem_burst,
    input logic               rsp_valid,
    input logic               dram_we,
    input logic               tag_we,
    input logic               tag_valid,
    input logic               fill_done,
    input logic               fill_err
);

    p_accept_opens_r1: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (busy && mem_req));

    p_request_held_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    p_rsp_in_fill_r5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(busy));

    p_valid_at_end_r6: assert property (@(posedge clk) disable iff (rst)
        (tag_we && tag_valid) |-> (fill_done && !fill_err));

    p_error_invalid_r7: assert property (@(posedge clk) disable iff (rst)
        (fill_done && fill_err) |-> !(tag_we && tag_valid));

    p_done_closes_r8: assert property (@(posedge clk) disable iff (rst)
        fill_done |=> !busy);

    p_bypass_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_burst) |-> (!dram_we && !tag_we));

    p_reset_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !mem_req && !rsp_valid && !dram_we && !tag_we));

endmodule

bind cwf_line_fill cwf_line_fill_chk #(.WADDR_W(WADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .busy      (busy),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_addr  (mem_addr),
    .mem_burst (mem_burst),
    .rsp_valid (rsp_valid),
    .dram_we   (dram_we),
    .tag_we    (tag_we),
    .tag_valid (tag_valid),
    .fill_done (fill_done),
    .fill_err  (fill_err)
);

// File: tb/cwf_line_fill_test.sv
module cwf_line_fill_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cache_en = 1'b1, req_valid = 1'b0;
    logic [29:0] req_addr = '0;
    logic [1:0]  victim_way = '0;
    logic        req_ready, busy;
    logic        seq_valid = 1'b0;
    logic [2:0]  seq_word = '0;
    logic        rsp_valid, rsp_err;
    logic [2:0]  rsp_word;
    logic [31:0] rsp_data;
    logic        mem_req, mem_burst;
    logic [29:0] mem_addr;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0, mem_rerr = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        dram_we, tag_we, tag_valid, fill_done, fill_err;
    logic [1:0]  dram_way, tag_way;
    logic [5:0]  dram_set, tag_set;
    logic [2:0]  dram_word;
    logic [31:0] dram_wdata;
    logic [20:0] tag_value;

    int n_chk = 0, n_fail = 0, cycles = 0;
    bit stream_on = 1'b0;
    logic [63:0] exp_dw[$], exp_tag[$], exp_rsp[$];

    always #10 clk = ~clk;

    cwf_line_fill uut (.*);

    function automatic logic [31:0] mem_data(logic [29:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A1234;
    endfunction

    task automatic chk_eq(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
                summary();
            end
        end
    end

    // Output monitor: each write or response is compared with the model queues.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (dram_we) begin
                    if (exp_dw.size() == 0) chk_eq("R3 unexpected data write", 64'(dram_word), 64'hFFFF);
                    else chk_eq("R3 data RAM write", {21'd0, dram_way, dram_set, dram_word, dram_wdata}, exp_dw.pop_front());
                end
                if (tag_we) begin
                    if (exp_tag.size() == 0) chk_eq("R6 unexpected tag write", 64'(tag_set), 64'hFFFF);
                    else chk_eq("R6 tag write", {34'd0, tag_valid, tag_way, tag_set, tag_value}, exp_tag.pop_front());
                end
                if (rsp_valid) begin
                    if (exp_rsp.size() == 0) chk_eq("R5 unexpected response", 64'(rsp_word), 64'hFFFF);
                    else chk_eq("R4 R5 response", {28'd0, rsp_err, rsp_word, rsp_data}, exp_rsp.pop_front());
                    if (stream_on && seq_valid && rsp_word == seq_word) begin
                        if (seq_word == req_addr[2:0] + 3'd7) seq_valid = 1'b0;
                        else seq_word = seq_word + 3'd1;
                    end
                end
            end
        end
    end

    task automatic do_txn(input logic [29:0] a, input logic [1:0] w, input bit en,
                          input logic [7:0] emask, input int gap, input bit stream, input bit hammer);
        int nb;
        logic [29:0] ba;
        nb = en ? 8 : 1;
        @(negedge clk);
        chk_eq("R1 ready when idle", 64'(req_ready), 64'd1);
        for (int k = 0; k < nb; k++) begin
            ba = en ? {a[29:3], a[2:0] + 3'(k)} : a;
            if (en && !emask[k]) exp_dw.push_back({21'd0, w, a[8:3], ba[2:0], mem_data(ba)});
            if (k == 0 || stream) exp_rsp.push_back({28'd0, emask[k], ba[2:0], mem_data(ba)});
        end
        if (en) begin
            exp_tag.push_back({34'd0, 1'b0, w, a[8:3], a[29:9]});
            exp_tag.push_back({34'd0, ~|emask, w, a[8:3], a[29:9]});
        end
        req_valid = 1'b1; req_addr = a; victim_way = w; cache_en = en;
        if (stream && en) begin
            stream_on = 1'b1; seq_valid = 1'b1; seq_word = a[2:0] + 3'd1;
        end
        @(negedge clk);
        req_valid = hammer;
        victim_way = ~w;           // R1: late changes must not matter
        cache_en = ~en;
        chk_eq("R1 busy after accept", {62'd0, busy, req_ready}, 64'b10);
        chk_eq("R2 R9 request address", 64'(mem_addr), 64'(a));
        chk_eq("R2 R9 burst type", {62'd0, mem_req, mem_burst}, {62'd0, 1'b1, en});
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            chk_eq("R2 request held", {31'd0, mem_req, 2'd0, mem_addr}, {31'd0, 1'b1, 2'd0, a});
        end
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        for (int k = 0; k < nb; k++) begin
            for (int i = 0; i < gap; i++) begin
                chk_eq("R1 R8 busy during fill", {62'd0, busy, req_ready}, 64'b10);
                @(negedge clk);
            end
            ba = en ? {a[29:3], a[2:0] + 3'(k)} : a;
            mem_rvalid = 1'b1; mem_rdata = mem_data(ba); mem_rerr = emask[k];
            @(negedge clk);
            mem_rvalid = 1'b0; mem_rerr = 1'b0;
        end
        while (!fill_done) @(negedge clk);
        chk_eq("R7 R9 fill_err", 64'(fill_err), 64'(en ? |emask : emask[0]));
        chk_eq("R8 busy with done", 64'(busy), 64'd1);
        req_valid = 1'b0;
        @(negedge clk);
        chk_eq("R8 busy drops", {62'd0, busy, req_ready}, 64'b01);
        stream_on = 1'b0; seq_valid = 1'b0;
        @(negedge clk);
        #1;
        chk_eq("R3 all data writes seen", 64'(exp_dw.size()), 64'd0);
        chk_eq("R6 all tag writes seen", 64'(exp_tag.size()), 64'd0);
        chk_eq("R4 R5 all responses seen", 64'(exp_rsp.size()), 64'd0);
        if (hammer) chk_eq("R1 no request taken while busy", {62'd0, mem_req, busy}, 64'd0);
        exp_dw.delete(); exp_tag.delete(); exp_rsp.delete();
    endtask

    initial begin
        int seed;
        repeat (3) @(negedge clk);
        chk_eq("R10 outputs in reset", {57'd0, busy, mem_req, rsp_valid, dram_we, tag_we, fill_done, req_ready}, 64'd1);
        rst = 1'b0;
        @(negedge clk);
        chk_eq("R10 outputs after reset", {57'd0, busy, mem_req, rsp_valid, dram_we, tag_we, fill_done, req_ready}, 64'd1);

        do_txn(30'h0123_4560, 2'd1, 1'b1, 8'h00, 0, 1'b0, 1'b0);   // R3 crit word 0
        do_txn(30'h0ABC_DE05, 2'd2, 1'b1, 8'h00, 2, 1'b1, 1'b0);   // R5 streaming with gaps
        do_txn(30'h1F00_0F33, 2'd3, 1'b1, 8'h00, 0, 1'b1, 1'b1);   // R1 hammer, back-to-back beats
        do_txn(30'h2222_3337, 2'd0, 1'b1, 8'h08, 1, 1'b1, 1'b0);   // R7 error on beat 3
        do_txn(30'h3456_789A, 2'd1, 1'b1, 8'h01, 0, 1'b0, 1'b0);   // R7 error on missed word
        do_txn(30'h0000_0106, 2'd2, 1'b0, 8'h00, 0, 1'b0, 1'b0);   // R9 bypass
        do_txn(30'h0777_7771, 2'd3, 1'b0, 8'h01, 3, 1'b0, 1'b0);   // R9 bypass with error

        // R5: sequential requests with no refill open are ignored
        seq_valid = 1'b1; seq_word = 3'd2;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk_eq("R5 idle sequential request ignored", 64'(rsp_valid), 64'd0);
        end
        seq_valid = 1'b0;

        seed = 32'h1357;
        for (int i = 0; i < 12; i++) begin
            seed = seed * 1103515245 + 12345;
            do_txn(30'(seed >> 2), 2'(seed >> 7), 1'b1, (i == 4) ? 8'h40 : 8'h00,
                   i % 3, i[0], 1'b0);
        end
        summary();
    end

endmodule